// File: doc/BRIEF.md
# Safe Intersection Phase Controller

This block sequences a two-approach road crossing. Each approach runs green, then yellow, then a shared all-red clearance. A pedestrian crossing interval is slotted in with all vehicle lamps red. Green time follows vehicle presence: a green is held for a minimum time and then stretched while cars keep arriving, up to a ceiling. An approach with no waiting traffic is passed over. A priority request, such as an emergency vehicle, cuts the running phase short through yellow and clearance and hands green to the approach it names. All durations are counted in ticks of a slow time base divided down from the system clock.

Safety sits in three layers. First, the lamp outputs pass through a gate that cannot light both greens. Second, a heartbeat watchdog forces a latched flashing-red state when the supervisor stops toggling its heartbeat pin. A gate conflict or an undefined state code also forces that state. Third, the state register decodes every unused code to flashing red. An eight-entry transition log records each state change with a tick timestamp. Software reads the log by index through a combinational port. Any index can be read in any cycle, so that port has no handshake and no back-pressure. All other pins are plain levels sampled on the rising clock edge.

Top module: `xsec_phase_ctl`

## Requirements
- R1: Lamp buses are 3 bits {red, yellow, green}: green 3'b001, yellow 3'b010, red 3'b100. A green is always followed by yellow for YEL_T ticks, then an all-red interval (both buses 3'b100) of CLR_T ticks, before any green is given.
- R2: When one approach shows green, the other approach shows red. Both greens are never lit together.
- R3: A pending pedestrian request is served after clearance with `walk` high and both buses red. Walk lasts at least WALK_T ticks. It is extended while `ped_req` stays high, up to WALK_MAX ticks, and it is followed by all-red clearance.
- R4: A green lasts at least MIN_GRN ticks. After that it ends only when there is demand elsewhere, and either its own presence input is low or MAX_GRN ticks have elapsed. With no other demand the green rests. After clearance, an approach without presence is skipped.
- R5: A `pri_req` pulse with `pri_b` (1 selects approach B) moves a conflicting green to yellow on the second clock edge, regardless of minimum green. Green then goes to the requested approach after yellow and all-red, even with no presence there.
- R6: If `heartbeat` has no edge for HB_LIMIT clock cycles, the controller enters flashing red. Both buses show 3'b100 on entry and alternate with 3'b000 on every tick. The state is held until `safe_clear`, which leads into all-red before any green.
- R7: Each state change writes an entry {old code[3:0], new code[3:0], timestamp[15:0]}. `hist_idx` 0 reads the newest entry, and older entries are overwritten once 8 have been written. The codes are: green A 4'h3, yellow A 4'h5, green B 4'h6, yellow B 4'h9, all-red 4'hA, walk 4'hC, flashing 4'hF.
- R8: During reset both buses are red, `walk` is low and every log entry reads zero.
- R9: A pedestrian request that arrives during yellow or all-red is kept pending and is served at the next clearance decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| safe_clear | input | 1 | Leaves flashing red via all-red |
| veh_a | input | 1 | Vehicle presence, approach A |
| veh_b | input | 1 | Vehicle presence, approach B |
| ped_req | input | 1 | Pedestrian crossing request |
| pri_req | input | 1 | Priority request strobe |
| pri_b | input | 1 | Priority target, 1 = approach B |
| heartbeat | input | 1 | Supervisor liveness toggle |
| lamp_a | output | 3 | Approach A lamps {red, yellow, green} |
| lamp_b | output | 3 | Approach B lamps {red, yellow, green} |
| walk | output | 1 | Pedestrian walk lamp |
| hist_idx | input | LOG_AW | Log entry index, 0 = newest |
| hist_data | output | HIST_W | Selected log entry |

## Verification
The bench builds the controller with a 4-cycle tick, minimum green 3, maximum green 6, yellow 2, clearance 1, walk 2 to 4 ticks and a 64-cycle heartbeat limit. With these values, the cut at maximum green, the walk cap and the skipping of an idle approach all occur within a few dozen ticks. Over 17 transitions the log wraps twice, so overwriting of the oldest entry can be observed. The watchdog trips within about a hundred cycles, so flashing, latching and the exit through all-red fit in a short run.

// File: rtl/xsec_pkg.sv
package xsec_pkg;
  // Phase codes are visible in the transition log, so their values are fixed.
  typedef enum logic [3:0] {
    ST_GRN_A = 4'h3,
    ST_YEL_A = 4'h5,
    ST_GRN_B = 4'h6,
    ST_YEL_B = 4'h9,
    ST_CLEAR = 4'hA,
    ST_WALK  = 4'hC,
    ST_FLASH = 4'hF
  } phase_e;
  localparam int PHASE_W = 4;
  localparam int LAMP_W  = 3;
endpackage

// File: rtl/xsec_tick_gen.sv
module xsec_tick_gen #(
  parameter int DIV  = 50_000_000,
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            tick,
  output logic [TS_W-1:0] ts
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      ts  <= '0;
    end else if (tick) begin
      cnt <= '0;
      ts  <= ts + TS_W'(1);
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/xsec_hb_watchdog.sv
module xsec_hb_watchdog #(
  parameter int LIMIT = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hb,
  output logic trip
);
  localparam int CW = $clog2(LIMIT + 1);
  logic          hb_q;
  logic [CW-1:0] idle;
  logic          hb_edge;

  assign hb_edge = hb ^ hb_q;
  assign trip    = (idle >= CW'(LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hb_q <= 1'b0;
      idle <= '0;
    end else begin
      hb_q <= hb;
      if (hb_edge)    idle <= '0;
      else if (!trip) idle <= idle + CW'(1);
    end
  end

  // R6: once tripped, only a heartbeat edge releases the trip
  p_wd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && !hb_edge) |=> trip);
endmodule

// File: rtl/xsec_trans_log.sv
module xsec_trans_log #(
  parameter int DEPTH = 8,
  parameter int TS_W  = 16,
  parameter int ST_W  = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int EW   = 2 * ST_W + TS_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [ST_W-1:0] old_st,
  input  logic [ST_W-1:0] new_st,
  input  logic [TS_W-1:0] ts,
  input  logic [AW-1:0]   rd_idx,
  output logic [EW-1:0]   rd_data
);
  logic [EW-1:0] ring [DEPTH];
  logic [AW-1:0] wptr;
  logic [AW-1:0] raddr;

  // DEPTH is a power of two, so pointer wrap is free
  assign raddr   = wptr - AW'(1) - rd_idx;
  assign rd_data = ring[raddr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      for (int i = 0; i < DEPTH; i++) ring[i] <= '0;
    end else if (wr_en) begin
      ring[wptr] <= {old_st, new_st, ts};
      wptr       <= wptr + AW'(1);
    end
  end

  // R7: every write advances the ring by exactly one slot
  p_log_adv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wptr == $past(wptr) + AW'(1)));
endmodule

// File: rtl/xsec_lamp_gate.sv
module xsec_lamp_gate (
  input  logic [1:0]      raw_g,
  input  logic [1:0]      raw_y,
  input  logic [1:0]      raw_r,
  input  logic            flash,
  input  logic            blink,
  output logic [1:0][2:0] lamps,
  output logic            conflict
);
  assign conflict = raw_g[0] & raw_g[1];

  // Each green is masked by the opposing green request; a masked green shows red.
  for (genvar i = 0; i < 2; i++) begin : g_lamp
    assign lamps[i] = flash ? {blink, 2'b00}
                            : {raw_r[i] | (raw_g[i] & raw_g[1-i]),
                               raw_y[i],
                               raw_g[i] & ~raw_g[1-i]};
  end
endmodule

// File: rtl/xsec_phase_ctl.sv
module xsec_phase_ctl
  import xsec_pkg::*;
#(
  parameter int TICK_DIV  = 50_000_000,
  parameter int MIN_GRN   = 10,
  parameter int MAX_GRN   = 40,
  parameter int YEL_T     = 3,
  parameter int CLR_T     = 2,
  parameter int WALK_T    = 7,
  parameter int WALK_MAX  = 14,
  parameter int HB_LIMIT  = 100_000_000,
  parameter int LOG_DEPTH = 8,
  parameter int TS_W      = 16,
  localparam int LOG_AW   = $clog2(LOG_DEPTH),
  localparam int HIST_W   = 2 * PHASE_W + TS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              safe_clear,
  input  logic              veh_a,
  input  logic              veh_b,
  input  logic              ped_req,
  input  logic              pri_req,
  input  logic              pri_b,
  input  logic              heartbeat,
  output logic [2:0]        lamp_a,
  output logic [2:0]        lamp_b,
  output logic              walk,
  input  logic [LOG_AW-1:0] hist_idx,
  output logic [HIST_W-1:0] hist_data
);
  localparam int TMR_MAX = (MAX_GRN > WALK_MAX) ? MAX_GRN : WALK_MAX;
  localparam int TMR_W   = $clog2(TMR_MAX + 2);

  phase_e           st, nxt, pick;
  logic [TMR_W-1:0] tmr;
  logic [TMR_W:0]   el;
  logic             tick, wd_trip, conflict;
  logic [TS_W-1:0]  ts;
  logic             ped_pend, pri_pend, pri_tgt_b, last_b, blink;
  logic [1:0]       raw_g, raw_y, raw_r;
  logic [1:0][2:0]  lamps;

  xsec_tick_gen #(.DIV(TICK_DIV), .TS_W(TS_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ts(ts));

  xsec_hb_watchdog #(.LIMIT(HB_LIMIT)) u_wd (
    .clk(clk), .rst_n(rst_n), .hb(heartbeat), .trip(wd_trip));

  // Ticks completed in this state, counting a tick in the current cycle
  assign el = {1'b0, tmr} + (TMR_W+1)'(1);

  // Clearance decision: priority, then pedestrian, then alternate by presence
  always_comb begin
    if (pri_pend)                               pick = pri_tgt_b ? ST_GRN_B : ST_GRN_A;
    else if (ped_pend)                          pick = ST_WALK;
    else if (last_b ? (veh_b & ~veh_a) : veh_b) pick = ST_GRN_B;
    else                                        pick = ST_GRN_A;
  end

  always_comb begin
    nxt = st;
    case (st)
      ST_GRN_A:
        if (pri_pend && pri_tgt_b) nxt = ST_YEL_A;
        else if (tick && el >= (TMR_W+1)'(MIN_GRN) && (veh_b || ped_pend) &&
                 (!veh_a || el >= (TMR_W+1)'(MAX_GRN))) nxt = ST_YEL_A;
      ST_GRN_B:
        if (pri_pend && !pri_tgt_b) nxt = ST_YEL_B;
        else if (tick && el >= (TMR_W+1)'(MIN_GRN) && (veh_a || ped_pend) &&
                 (!veh_b || el >= (TMR_W+1)'(MAX_GRN))) nxt = ST_YEL_B;
      ST_YEL_A, ST_YEL_B:
        if (tick && el >= (TMR_W+1)'(YEL_T)) nxt = ST_CLEAR;
      ST_CLEAR:
        if (tick && el >= (TMR_W+1)'(CLR_T)) nxt = pick;
      ST_WALK:
        if (pri_pend) nxt = ST_CLEAR;
        else if (tick && el >= (TMR_W+1)'(WALK_T) &&
                 (!ped_req || el >= (TMR_W+1)'(WALK_MAX))) nxt = ST_CLEAR;
      ST_FLASH:
        if (safe_clear) nxt = ST_CLEAR;
      default: nxt = ST_FLASH;
    endcase
    if (wd_trip || conflict) nxt = ST_FLASH;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_CLEAR;
      tmr       <= '0;
      ped_pend  <= 1'b0;
      pri_pend  <= 1'b0;
      pri_tgt_b <= 1'b0;
      last_b    <= 1'b1;
      blink     <= 1'b1;
    end else begin
      st <= nxt;
      if (nxt != st)                          tmr <= '0;
      else if (tick && tmr != {TMR_W{1'b1}}) tmr <= tmr + TMR_W'(1);
      if (nxt == ST_GRN_B && st != ST_GRN_B) last_b <= 1'b1;
      if (nxt == ST_GRN_A && st != ST_GRN_A) last_b <= 1'b0;
      if (nxt == ST_WALK) ped_pend <= 1'b0;
      else                ped_pend <= ped_pend | (ped_req & (st != ST_WALK));
      if (pri_req) begin
        pri_pend  <= 1'b1;
        pri_tgt_b <= pri_b;
      end else if ((st == ST_GRN_A && !pri_tgt_b) || (st == ST_GRN_B && pri_tgt_b)) begin
        pri_pend <= 1'b0;
      end
      if (nxt == ST_FLASH && st != ST_FLASH) blink <= 1'b1;
      else if (st == ST_FLASH && tick)       blink <= ~blink;
    end
  end

  assign raw_g = {st == ST_GRN_B, st == ST_GRN_A};
  assign raw_y = {st == ST_YEL_B, st == ST_YEL_A};
  assign raw_r = ~(raw_g | raw_y);

  xsec_lamp_gate u_gate (
    .raw_g(raw_g), .raw_y(raw_y), .raw_r(raw_r),
    .flash(st == ST_FLASH), .blink(blink),
    .lamps(lamps), .conflict(conflict));

  assign lamp_a = lamps[0];
  assign lamp_b = lamps[1];
  assign walk   = (st == ST_WALK);

  xsec_trans_log #(.DEPTH(LOG_DEPTH), .TS_W(TS_W), .ST_W(PHASE_W)) u_log (
    .clk(clk), .rst_n(rst_n), .wr_en(nxt != st),
    .old_st(st), .new_st(nxt), .ts(ts),
    .rd_idx(hist_idx), .rd_data(hist_data));

  // R2: a green on one approach is matched by red on the other
  p_a_green_b_red_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lamp_a[0] |-> (lamp_b == 3'b100));
  p_b_green_a_red_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lamp_b[0] |-> (lamp_a == 3'b100));
  // R1: yellow is left only for clearance (or the safe state)
  p_yel_then_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_YEL_A && st != ST_YEL_A) |-> (st == ST_CLEAR || st == ST_FLASH));
  // R4: with demand elsewhere, a green ends at the maximum
  p_max_green_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GRN_A && tick && tmr >= TMR_W'(MAX_GRN - 1) && (veh_b || ped_pend))
      |=> (st != ST_GRN_A));
  // R3: walk shows only with all vehicle lamps red
  p_walk_all_red_r3: assert property (@(posedge clk) disable iff (!rst_n)
    walk |-> (lamp_a == 3'b100 && lamp_b == 3'b100));
  // R6: the safe state is latched and entered on a watchdog trip
  p_flash_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FLASH && !safe_clear) |=> (st == ST_FLASH));
  p_trip_flash_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_trip |=> (st == ST_FLASH));
endmodule

// File: tb/xsec_phase_ctl_test.sv
module xsec_phase_ctl_test;
  localparam int TDIV = 4;
  localparam int HBL  = 64;
  localparam int NV   = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic safe_clear = 1'b0, veh_a = 1'b0, veh_b = 1'b0, ped_req = 1'b0;
  logic pri_req = 1'b0, pri_b = 1'b0, heartbeat = 1'b0;
  logic hb_en = 1'b1;
  logic [2:0]  lamp_a, lamp_b;
  logic        walk;
  logic [2:0]  hist_idx = 3'd0;
  logic [23:0] hist_data;
  int n_chk = 0, n_fail = 0, dual_g = 0;

  always #5 clk = ~clk;

  xsec_phase_ctl #(
    .TICK_DIV(TDIV), .MIN_GRN(3), .MAX_GRN(6), .YEL_T(2), .CLR_T(1),
    .WALK_T(2), .WALK_MAX(4), .HB_LIMIT(HBL), .LOG_DEPTH(8), .TS_W(16)
  ) uut (
    .clk(clk), .rst_n(rst_n), .safe_clear(safe_clear), .veh_a(veh_a), .veh_b(veh_b),
    .ped_req(ped_req), .pri_req(pri_req), .pri_b(pri_b), .heartbeat(heartbeat),
    .lamp_a(lamp_a), .lamp_b(lamp_b), .walk(walk),
    .hist_idx(hist_idx), .hist_data(hist_data));

  initial forever begin
    repeat (8) @(negedge clk);
    if (hb_en) heartbeat = ~heartbeat;
  end

  always @(negedge clk) if (rst_n && lamp_a[0] && lamp_b[0]) dual_g++;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // {veh_a, veh_b, ped_req, ticks to wait[3:0], exp lamp_a, exp lamp_b, exp walk, req tag[3:0]}
  localparam logic [17:0] VEC [NV] = '{
    {3'b100, 4'd1, 3'b001, 3'b100, 1'b0, 4'd4},  // R4 first green goes to A
    {3'b110, 4'd2, 3'b001, 3'b100, 1'b0, 4'd4},  // R4 minimum green
    {3'b110, 4'd2, 3'b001, 3'b100, 1'b0, 4'd4},  // R4 extension on presence
    {3'b110, 4'd2, 3'b010, 3'b100, 1'b0, 4'd4},  // R4 cut at maximum green
    {3'b110, 4'd1, 3'b010, 3'b100, 1'b0, 4'd1},  // R1 yellow held YEL_T
    {3'b110, 4'd1, 3'b100, 3'b100, 1'b0, 4'd1},  // R1 all-red clearance
    {3'b110, 4'd1, 3'b100, 3'b001, 1'b0, 4'd1},  // R1 then green B
    {3'b000, 4'd4, 3'b100, 3'b001, 1'b0, 4'd4},  // R4 rest in green
    {3'b110, 4'd1, 3'b100, 3'b001, 1'b0, 4'd4},  // R4 extension on B
    {3'b100, 4'd1, 3'b100, 3'b010, 1'b0, 4'd4},  // R4 cut at maximum on B
    {3'b101, 4'd3, 3'b100, 3'b100, 1'b1, 4'd9},  // R9 request during yellow served
    {3'b101, 4'd3, 3'b100, 3'b100, 1'b1, 4'd3},  // R3 walk extended
    {3'b100, 4'd1, 3'b100, 3'b100, 1'b0, 4'd3},  // R3 walk capped then clear
    {3'b100, 4'd1, 3'b001, 3'b100, 1'b0, 4'd4},  // R4 back to A
    {3'b001, 4'd3, 3'b010, 3'b100, 1'b0, 4'd4},  // R4 ped demand ends idle green
    {3'b000, 4'd3, 3'b100, 3'b100, 1'b1, 4'd3},  // R3 walk served
    {3'b000, 4'd2, 3'b100, 3'b100, 1'b0, 4'd3},  // R3 walk minimum then clear
    {3'b000, 4'd1, 3'b001, 3'b100, 1'b0, 4'd4}   // R4 idle B skipped
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [17:0] row;
    logic saw_y, saw_r, found, saw_g;
    logic [15:0] ts0, ts1;

    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 reset lamps", {25'd0, lamp_a, lamp_b, walk}, {25'd0, 3'b100, 3'b100, 1'b0});
    chk("R8 reset log", {8'd0, hist_data}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      row = VEC[i];
      veh_a = row[17]; veh_b = row[16]; ped_req = row[15];
      repeat (TDIV * int'(row[14:11])) @(posedge clk);
      @(negedge clk);
      chk($sformatf("R%0d vector %0d lamps", row[3:0], i),
          {25'd0, lamp_a, lamp_b, walk}, {25'd0, row[10:4]});
    end

    // R5 preemption toward B with no presence there
    veh_a = 1'b0; veh_b = 1'b0;
    pri_b = 1'b1; pri_req = 1'b1;
    @(negedge clk); pri_req = 1'b0;
    @(negedge clk);
    chk("R5 green A cut to yellow", {29'd0, lamp_a}, {29'd0, 3'b010});
    saw_y = 1'b1; saw_r = 1'b0; found = 1'b0;
    for (int c = 0; c < 60 && !found; c++) begin
      @(negedge clk);
      if (lamp_a == 3'b100 && lamp_b == 3'b100) saw_r = 1'b1;
      if (lamp_b == 3'b001) found = 1'b1;
    end
    chk("R5 priority green reached", {31'd0, found}, 32'd1);
    chk("R5 clearance before priority green", {30'd0, saw_y, saw_r}, {30'd0, 2'b11});

    // R7 log contents, newest first, and wrap of the oldest entries
    hist_idx = 3'd0; #1;
    chk("R7 idx0 codes", {24'd0, hist_data[23:16]}, 32'hA6);
    ts0 = hist_data[15:0];
    hist_idx = 3'd1; #1;
    chk("R7 idx1 codes", {24'd0, hist_data[23:16]}, 32'h5A);
    ts1 = hist_data[15:0];
    chk("R7 clearance stamp gap", {16'd0, ts0 - ts1}, 32'd1);
    hist_idx = 3'd2; #1;
    chk("R7 idx2 codes", {24'd0, hist_data[23:16]}, 32'h35);
    hist_idx = 3'd3; #1;
    chk("R7 idx3 codes", {24'd0, hist_data[23:16]}, 32'hA3);
    hist_idx = 3'd7; #1;
    chk("R7 idx7 after wrap", {24'd0, hist_data[23:16]}, 32'h35);
    hist_idx = 3'd0;

    // R6 heartbeat loss
    hb_en = 1'b0;
    found = 1'b0;
    for (int c = 0; c < HBL + 60 && !found; c++) begin
      @(negedge clk);
      if (lamp_b != 3'b001) found = 1'b1;
    end
    chk("R6 flash on entry", {25'd0, lamp_a, lamp_b, walk}, {25'd0, 3'b100, 3'b100, 1'b0});
    repeat (TDIV) @(negedge clk);
    chk("R6 flash dark half", {26'd0, lamp_a, lamp_b}, 32'd0);
    repeat (TDIV) @(negedge clk);
    chk("R6 flash lit half", {26'd0, lamp_a, lamp_b}, {26'd0, 3'b100, 3'b100});
    hb_en = 1'b1; veh_a = 1'b1; veh_b = 1'b1;
    saw_g = 1'b0;
    for (int c = 0; c < 5 * TDIV; c++) begin
      @(negedge clk);
      if (lamp_a[1:0] != 2'b00 || lamp_b[1:0] != 2'b00) saw_g = 1'b1;
    end
    chk("R6 flash latched after heartbeat returns", {31'd0, saw_g}, 32'd0);
    safe_clear = 1'b1;
    @(negedge clk); safe_clear = 1'b0;
    chk("R6 exit via all-red", {26'd0, lamp_a, lamp_b}, {26'd0, 3'b100, 3'b100});
    found = 1'b0;
    for (int c = 0; c < 40 && !found; c++) begin
      @(negedge clk);
      if (lamp_a == 3'b001 || lamp_b == 3'b001) found = 1'b1;
    end
    chk("R6 normal service resumes", {31'd0, found}, 32'd1);

    chk("R2 no dual green seen", dual_g, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule